// File: doc/BRIEF.md
# Retention power-down and restart sequencer

This controller decides when a small microcontroller core may run, when its oscillator may stop, and how the core comes back afterwards. Software issues a power-off strobe. The sequencer then gates the oscillator enable off and parks in a retention state, where RAM keeps its contents. It also raises a one-cycle strobe that loads the stack pointer with all ones.

The core leaves retention in one of two ways. An external wake-up pin gives a warm start. Any of three reset sources gives a cold start: power-on, watchdog or supply-voltage drop. A reset also forces a cold start from the running state. Both restart paths turn the oscillator back on and hold the core for a fixed stabilisation count. At the end of the count they raise run together with a one-cycle program-counter reset request.

A single flag records the kind of start. The power-off strobe sets it and any reset clears it. Software reads it through a dedicated test output to tell a warm start from a cold one.

Top module: `retention_sequencer`

## Requirements
- R1: Any of the three reset inputs, sampled high at a clock edge, puts the block into STABILISE with the oscillator enable high and run low, and restarts the stabilisation count from zero. This happens from every state.
- R2: A power-off strobe while in RUN moves the block to BACKUP at the next edge. In BACKUP the oscillator enable and run are both low.
- R3: On the edge that enters BACKUP, the stack-pointer load strobe is high for exactly one cycle, and the stack-pointer init value output reads binary 11.
- R4: In BACKUP, a wake-up input passes through a two-flop synchroniser. A wake level present at edge k moves the block to STABILISE at edge k+2, with the oscillator enable high.
- R5: A wake-up input in RUN or STABILISE is ignored. The state does not change and the stabilisation length is unaffected.
- R6: Run rises exactly STAB_CYCLES (default 16384) clock edges after the edge that entered STABILISE, or after the last edge that saw a reset. The count advances only while the oscillator enable is high.
- R7: The program-counter reset request is high for exactly the one cycle in which run first becomes high, on both warm and cold starts.
- R8: The power-down flag is set by an accepted power-off strobe and cleared by any reset input. It therefore reads 1 after a warm start and 0 after a cold start.
- R9: When a reset and a power-off strobe arrive at the same edge, the reset wins. The flag reads 0 and the block enters STABILISE.
- R10: A power-off strobe outside RUN is ignored. The state and the flag are unchanged.
- R11: The state output encodes RUN as 0, BACKUP as 1 and STABILISE as 2. The value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock; the oscillator is modelled by the osc_en clock enable |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| wdt_rst | input | 1 | Watchdog reset, synchronous, active high |
| vdrop_rst | input | 1 | Supply-voltage-drop reset, synchronous, active high |
| pof_cmd | input | 1 | One-cycle power-off strobe from the CPU |
| wake_in | input | 1 | Asynchronous external wake-up input |
| osc_en | output | 1 | Oscillator enable (clock enable for the core) |
| cpu_run | output | 1 | CPU execution enable |
| pc_reset | output | 1 | One-cycle request to load the program counter with page 0, address 0 |
| sp_init | output | 1 | One-cycle stack-pointer initialise strobe |
| sp_init_value | output | SP_W | Value loaded into the stack pointer (all ones) |
| pd_flag_test | output | 1 | Power-down flag as seen by the skip-if-flag-set test |
| state_o | output | 2 | Current state: 0 RUN, 1 BACKUP, 2 STABILISE |

## Verification
The bench drives random sequences of run periods, power-off strobes and retention dwell times. In each round it picks the exit at random from wake-up, watchdog reset and voltage-drop reset. The flag value seen at restart then tells the warm path from the cold path, and the measured gap from oscillator-on to run exposes any off-by-one in the stabilisation count. Stray wake-up pulses in RUN and in STABILISE, and power-off strobes in BACKUP and STABILISE, show that inputs are acted on only in their own state. Directed cases cover a reset coinciding with a power-off strobe and a reset in the middle of stabilisation, which must restart the full count.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_BACKUP = 2'd1,
    ST_STAB   = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/pwrseq_wake_sync.sv
module pwrseq_wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b0;
    else     chain_q[0] <= async_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[i] <= 1'b0;
      else     chain_q[i] <= chain_q[i-1];
    end
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pwrseq_stab_timer.sv
module pwrseq_stab_timer #(
  parameter int STAB_CYCLES = 16384
) (
  input  logic clk,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int CNT_W = (STAB_CYCLES > 2) ? $clog2(STAB_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr)                     cnt_q <= '0;
    else if (en && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done = en && (cnt_q == LAST);
endmodule

// File: rtl/pwrseq_pd_flag.sv
module pwrseq_pd_flag (
  input  logic clk,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (clr)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
  end
endmodule

// File: rtl/retention_sequencer.sv
module retention_sequencer
  import pwrseq_pkg::*;
#(
  parameter int STAB_CYCLES = 16384,
  parameter int SYNC_STAGES = 2,
  parameter int SP_W        = 2
) (
  input  logic            clk,
  input  logic            por_rst,
  input  logic            wdt_rst,
  input  logic            vdrop_rst,
  input  logic            pof_cmd,
  input  logic            wake_in,
  output logic            osc_en,
  output logic            cpu_run,
  output logic            pc_reset,
  output logic            sp_init,
  output logic [SP_W-1:0] sp_init_value,
  output logic            pd_flag_test,
  output logic [1:0]      state_o
);
  pwr_state_e state_q, state_d;
  logic rst_any, wake_s, tmr_clr, tmr_en, tmr_done, flag_set;

  assign rst_any = por_rst | wdt_rst | vdrop_rst;

  pwrseq_wake_sync #(.STAGES(SYNC_STAGES)) u_wake_sync (
    .clk      (clk),
    .rst      (rst_any),
    .async_in (wake_in),
    .sync_out (wake_s)
  );

  assign tmr_clr = rst_any | (state_q == ST_BACKUP && wake_s);
  assign tmr_en  = (state_q == ST_STAB) && osc_en;

  pwrseq_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_stab_timer (
    .clk  (clk),
    .clr  (tmr_clr),
    .en   (tmr_en),
    .done (tmr_done)
  );

  assign flag_set = (state_q == ST_RUN) && pof_cmd;

  pwrseq_pd_flag u_pd_flag (
    .clk  (clk),
    .set  (flag_set),
    .clr  (rst_any),
    .flag (pd_flag_test)
  );

  always_comb begin
    state_d = state_q;
    if (rst_any) begin
      state_d = ST_STAB;
    end else begin
      unique case (state_q)
        ST_RUN:    if (pof_cmd)  state_d = ST_BACKUP;
        ST_BACKUP: if (wake_s)   state_d = ST_STAB;
        ST_STAB:   if (tmr_done) state_d = ST_RUN;
        default:                 state_d = ST_STAB;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    state_q  <= state_d;
    osc_en   <= (state_d != ST_BACKUP);
    cpu_run  <= (state_d == ST_RUN);
    pc_reset <= (state_q == ST_STAB) && (state_d == ST_RUN);
    sp_init  <= (state_q == ST_RUN) && (state_d == ST_BACKUP);
  end

  assign sp_init_value = {SP_W{1'b1}};
  assign state_o       = state_q;
endmodule

// File: rtl/retention_sequencer_chk.sv
module pwrseq_checker
  import pwrseq_pkg::*;
#(
  parameter int STAB_CYCLES = 16384,
  parameter int SP_W        = 2
) (
  input logic            clk,
  input logic            por_rst,
  input logic            wdt_rst,
  input logic            vdrop_rst,
  input logic            pof_cmd,
  input logic            osc_en,
  input logic            cpu_run,
  input logic            pc_reset,
  input logic            sp_init,
  input logic [SP_W-1:0] sp_init_value,
  input logic            pd_flag_test,
  input logic [1:0]      state_o
);
  localparam int LEN_W = $clog2(STAB_CYCLES + 2) + 1;
  logic [LEN_W-1:0] stab_len;
  logic             soft_rst;

  assign soft_rst = wdt_rst | vdrop_rst;

  always_ff @(posedge clk) begin
    if (por_rst || soft_rst)     stab_len <= '0;
    else if (state_o == ST_STAB) stab_len <= stab_len + 1'b1;
    else                         stab_len <= '0;
  end

  AST_RST_ENTERS_STAB: assert property (@(posedge clk) disable iff (por_rst)
    soft_rst |=> (state_o == ST_STAB) && osc_en && !cpu_run); // R1
  AST_POF_ENTERS_BACKUP: assert property (@(posedge clk) disable iff (por_rst)
    (state_o == ST_RUN) && pof_cmd && !soft_rst |=> (state_o == ST_BACKUP) && pd_flag_test); // R2
  AST_BACKUP_CLOCK_OFF: assert property (@(posedge clk) disable iff (por_rst)
    (state_o == ST_BACKUP) |-> !osc_en && !cpu_run); // R2
  AST_SP_STROBE: assert property (@(posedge clk) disable iff (por_rst)
    sp_init |-> (state_o == ST_BACKUP) && (sp_init_value == {SP_W{1'b1}}) && $past(state_o == ST_RUN)); // R3
  AST_RUN_STAYS: assert property (@(posedge clk) disable iff (por_rst)
    (state_o == ST_RUN) && !pof_cmd && !soft_rst |=> (state_o == ST_RUN)); // R5
  AST_STAB_LENGTH: assert property (@(posedge clk) disable iff (por_rst)
    (cpu_run && !$past(cpu_run)) |-> (stab_len == LEN_W'(STAB_CYCLES))); // R6
  AST_PC_WITH_RUN: assert property (@(posedge clk) disable iff (por_rst)
    pc_reset |-> cpu_run && !$past(cpu_run)); // R7
  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (por_rst)
    soft_rst |=> !pd_flag_test); // R9
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (por_rst)
    state_o != 2'd3); // R11
endmodule

bind retention_sequencer pwrseq_checker #(.STAB_CYCLES(STAB_CYCLES), .SP_W(SP_W)) u_chk (
  .clk           (clk),
  .por_rst       (por_rst),
  .wdt_rst       (wdt_rst),
  .vdrop_rst     (vdrop_rst),
  .pof_cmd       (pof_cmd),
  .osc_en        (osc_en),
  .cpu_run       (cpu_run),
  .pc_reset      (pc_reset),
  .sp_init       (sp_init),
  .sp_init_value (sp_init_value),
  .pd_flag_test  (pd_flag_test),
  .state_o       (state_o)
);

// File: tb/retention_sequencer_tb.sv
module retention_sequencer_tb;
  localparam int STAB = 16384;
  localparam int SPW  = 2;

  logic clk = 1'b0;
  logic por_rst = 1'b1, wdt_rst = 1'b0, vdrop_rst = 1'b0, pof_cmd = 1'b0, wake_in = 1'b0;
  logic osc_en, cpu_run, pc_reset, sp_init, pd_flag_test;
  logic [SPW-1:0] sp_init_value;
  logic [1:0] state_o;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  retention_sequencer #(.STAB_CYCLES(STAB), .SP_W(SPW)) u_dut (
    .clk(clk), .por_rst(por_rst), .wdt_rst(wdt_rst), .vdrop_rst(vdrop_rst),
    .pof_cmd(pof_cmd), .wake_in(wake_in), .osc_en(osc_en), .cpu_run(cpu_run),
    .pc_reset(pc_reset), .sp_init(sp_init), .sp_init_value(sp_init_value),
    .pd_flag_test(pd_flag_test), .state_o(state_o)
  );

  function automatic int exp_stab_len();
    return STAB;
  endfunction

  function automatic int exp_flag(bit warm);
    return warm ? 1 : 0;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk_state(string req, int expv);
    check(int'(state_o) == expv, req, int'(state_o), expv);
  endtask

  task automatic wait_run(bit inject, output int n);
    n = 0;
    while (!cpu_run && n < 20000) begin
      if (inject && n == 100) wake_in = 1'b1;
      if (inject && n == 101) wake_in = 1'b0;
      if (inject && n == 200) pof_cmd = 1'b1;
      if (inject && n == 201) pof_cmd = 1'b0;
      step();
      n++;
    end
  endtask

  task automatic finish_restart(bit warm, bit inject);
    int n;
    wait_run(inject, n);
    check(n == exp_stab_len(), "R6 stabilise length", n, exp_stab_len());
    check(pc_reset == 1'b1, "R7 pc reset with run", int'(pc_reset), 1);
    check(int'(pd_flag_test) == exp_flag(warm), "R8 flag at restart", int'(pd_flag_test), exp_flag(warm));
    chk_state("R11 run code", 0);
    step();
    check(pc_reset == 1'b0, "R7 pc reset one cycle", int'(pc_reset), 0);
  endtask

  task automatic enter_backup();
    pof_cmd = 1'b1;
    step();
    pof_cmd = 1'b0;
    chk_state("R2 backup entered", 1);
    check(!osc_en && !cpu_run, "R2 clock off", int'({osc_en, cpu_run}), 0);
    check(sp_init == 1'b1, "R3 sp strobe", int'(sp_init), 1);
    check(sp_init_value == 2'b11, "R3 sp value", int'(sp_init_value), 3);
    check(pd_flag_test == 1'b1, "R8 flag set", int'(pd_flag_test), 1);
    step();
    check(sp_init == 1'b0, "R3 sp strobe one cycle", int'(sp_init), 0);
  endtask

  task automatic pulse_reset(int which);
    if (which == 1) wdt_rst = 1'b1; else vdrop_rst = 1'b1;
    step();
    wdt_rst = 1'b0;
    vdrop_rst = 1'b0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int gap, mode;
    void'($urandom(32'd20240611));
    repeat (3) step();
    chk_state("R1 reset state", 2);
    check(osc_en && !cpu_run, "R1 reset outputs", int'({osc_en, cpu_run}), 2);
    check(pd_flag_test == 1'b0, "R8 flag after power-on", int'(pd_flag_test), 0);
    por_rst = 1'b0;
    finish_restart(1'b0, 1'b0);

    for (int it = 0; it < 6; it++) begin
      gap = 2 + int'($urandom % 12);
      for (int k = 0; k < gap; k++) begin
        wake_in = ($urandom % 2) == 0;
        step();
        chk_state("R5 wake ignored in run", 0);
      end
      wake_in = 1'b0;
      repeat (3) step();
      chk_state("R5 still running", 0);
      enter_backup();
      gap = 1 + int'($urandom % 8);
      for (int k = 0; k < gap; k++) step();
      pof_cmd = 1'b1;
      step();
      pof_cmd = 1'b0;
      chk_state("R10 pof ignored in backup", 1);
      check(pd_flag_test == 1'b1, "R10 flag kept", int'(pd_flag_test), 1);
      mode = (it < 3) ? (it % 3) : int'($urandom % 3);
      if (mode == 0) begin
        wake_in = 1'b1;
        step();
        wake_in = 1'b0;
        chk_state("R4 sync stage 1", 1);
        step();
        chk_state("R4 sync stage 2", 1);
        step();
        chk_state("R4 wake to stabilise", 2);
        check(osc_en == 1'b1, "R4 osc on", int'(osc_en), 1);
        finish_restart(1'b1, 1'b1);
      end else begin
        pulse_reset(mode);
        chk_state("R1 reset from backup", 2);
        check(osc_en == 1'b1, "R1 osc on", int'(osc_en), 1);
        check(pd_flag_test == 1'b0, "R8 flag cleared", int'(pd_flag_test), 0);
        finish_restart(1'b0, 1'b1);
      end
    end

    pof_cmd = 1'b1;
    wdt_rst = 1'b1;
    step();
    pof_cmd = 1'b0;
    wdt_rst = 1'b0;
    chk_state("R9 reset beats pof", 2);
    check(pd_flag_test == 1'b0, "R9 flag stays clear", int'(pd_flag_test), 0);
    repeat (500) step();
    pulse_reset(2);
    chk_state("R1 reset mid-stabilise", 2);
    finish_restart(1'b0, 1'b0);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule